// File: doc/BRIEF.md
# DRAM Strobe and Refresh Controller

This block drives the row strobe, the two column strobes and the two write strobes for a DRAM that occupies one address area. It takes a single read or write request, splits the address into a row and a column, places each on a shared address bus in its phase, and pulses a done flag when the transfer completes. It also runs a refresh cycle in which the column strobes fall before the row strobe, started by a request input.

Configuration inputs choose how bytes are selected: two column strobes sharing one write strobe, or one column strobe with two write strobes. Other inputs select separate read and write column pitches, where the long pitch can be stretched by an external wait input. A mode input keeps the row open between transfers, so that a later access to the same row skips the row phase. An enable input gates the whole controller. A request is a single-cycle strobe. It is taken only while the controller is idle or holding a row open, and it is ignored at any other time.

Top module: `dram_strobe_ctrl`

## Requirements
- R1: After reset, and while `dram_en` is 0 with no transfer in progress, `ras_n`, both CAS strobes and both write strobes are high and `done` is low. Requests and refresh requests are then ignored.
- R2: An access from the idle state spends one row state (RAS low, both CAS high), then the column phase (RAS low, the selected CAS low). `done` is high for exactly one cycle, in the state that follows the last column state.
- R3: The word address is `req_addr[16:1]` when `req_bus16`=1 and `req_addr[15:0]` when it is 0. The row is its upper 8 bits and the column its lower 8 bits. `mux_addr` carries the row in the row state and holds the column steady through the column phase.
- R4: With `cfg_dual_we`=0 on a 16-bit access, `req_word`=1 selects both bytes. Otherwise `req_addr[0]`=0 selects the upper byte and 1 the lower byte. The upper byte drives `cas_hi_n` and the lower byte drives `cas_lo_n`. A write asserts only `we_lo_n`.
- R5: With `cfg_dual_we`=1 on a 16-bit access, `cas_lo_n` is asserted for every byte selection. A write asserts `we_hi_n` for the upper byte and `we_lo_n` for the lower byte. A read asserts neither write strobe.
- R6: With `req_bus16`=0, only `cas_lo_n` and, for a write, `we_lo_n` are asserted, whatever `cfg_dual_we` and `req_word` say.
- R7: When the pitch bit for the access direction (`cfg_rd_long` for reads, `cfg_wr_long` for writes) is 0, the column phase lasts 1 state and `wait_n` is ignored. When it is 1, the phase lasts 2 states plus one more for each rising clock edge in the second state at which `wait_n` is low.
- R8: With `cfg_ras_down`=0, RAS is high after every transfer. With it at 1, RAS stays low after an access. The next access to the same row then goes straight to the column phase. An access to a different row first raises RAS for one precharge state and then runs a row state.
- R9: If `cfg_ras_down` or `dram_en` is 0 while a row is held open, RAS goes high in the next state.
- R10: A refresh (`rfsh_req`) takes one state with both CAS low and RAS high. It then holds both low for 1 state, plus `cfg_rfsh_wait` states when `cfg_rd_long`=1, ignoring `wait_n`. It then releases both and pulses `done`. From an open row, one precharge state comes first. A refresh request wins over an access request in the same cycle, and that access is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dram_en | input | 1 | Enables the DRAM controller |
| cfg_dual_we | input | 1 | 0: two CAS, one write strobe; 1: one CAS, two write strobes |
| cfg_ras_down | input | 1 | Keep RAS low between accesses |
| cfg_rd_long | input | 1 | Long column pitch for reads |
| cfg_wr_long | input | 1 | Long column pitch for writes |
| cfg_rfsh_wait | input | 2 | Extra refresh states when the read pitch is long |
| req_valid | input | 1 | Single-cycle access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit transfer, 0 = byte |
| req_bus16 | input | 1 | Target space is 16 bits wide |
| req_addr | input | 17 | Byte address |
| rfsh_req | input | 1 | Single-cycle refresh request |
| wait_n | input | 1 | Active-low wait request |
| ras_n | output | 1 | Row address strobe |
| cas_hi_n | output | 1 | Upper-byte column strobe |
| cas_lo_n | output | 1 | Lower-byte column strobe |
| we_hi_n | output | 1 | Upper-byte write strobe |
| we_lo_n | output | 1 | Lower-byte write strobe |
| mux_addr | output | 8 | Multiplexed row/column address |
| done | output | 1 | One-cycle completion pulse |

## Verification
Checked on every cycle:
- `done` never lasts two cycles.
- Whenever RAS falls with CAS low, CAS was already low in the state before.
- A short column phase never lasts longer than one state, and a precharge state always lasts exactly one state.
- A disabled idle controller stays idle, and an open row closes as soon as RAS-down mode is withdrawn.
- The column address stays stable through the column phase.
- Narrow transfers and reads never raise the wrong write or column strobe.

Left to the bench scenarios:
- The exact latency of each path: idle, row hit, row miss, refresh from idle and refresh from an open row.
- The stretch of the long pitch by the wait input, and that the short pitch ignores it.
- The byte-lane pattern for every select mode and space width.
- The row and column values seen on the address bus.

// File: rtl/dram_ctl_pkg.sv
// Shared types for the DRAM strobe controller.
// Assumes: a single sequencer owns the state; the other blocks decode it.
package dram_ctl_pkg;

    // Sequencer states. OPEN holds a row with RAS low between accesses.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_OPEN = 3'd1,
        ST_PRE  = 3'd2,
        ST_ROW  = 3'd3,
        ST_COL  = 3'd4,
        ST_RFC  = 3'd5,
        ST_RFR  = 3'd6
    } dstate_e;

    // Attributes of the accepted transfer, captured when it is taken.
    typedef struct packed {
        logic write;
        logic word;
        logic a0;
        logic bus16;
        logic dual_we;
    } xfer_t;

endpackage

// File: rtl/dram_seq.sv
// Cycle sequencer for row/column accesses and refresh cycles.
// Assumes: requests are single-cycle strobes, taken only in IDLE or OPEN;
// the wait input is already synchronised to clk.
module dram_seq
    import dram_ctl_pkg::*;
#(
    parameter int RFW_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dram_en_i,
    input  logic             cfg_ras_down_i,
    input  logic             cfg_rd_long_i,
    input  logic             cfg_wr_long_i,
    input  logic [RFW_W-1:0] cfg_rfsh_wait_i,
    input  logic             req_valid_i,
    input  logic             req_write_i,
    input  logic             rfsh_req_i,
    input  logic             row_hit_i,
    input  logic             wait_n_i,
    output dstate_e          state_o,
    output logic             take_o,
    output logic             done_o
);

    dstate_e          st_q, st_d;
    logic             ph_q;
    logic             long_q;
    logic             pre_rf_q, pre_rf_d;
    logic [RFW_W-1:0] cnt_q;
    logic             done_q;
    logic             col_end;
    logic             rf_end;
    logic             hold_open;

    // Column phase ends after one state, or after the second state once wait is released
    assign col_end   = (st_q == ST_COL) && (!long_q || (ph_q && wait_n_i));
    // Refresh ends when the inserted wait count has run out
    assign rf_end    = (st_q == ST_RFR) && (cnt_q == '0);
    // A row may stay open only while enabled and in RAS-down mode
    assign hold_open = dram_en_i && cfg_ras_down_i;

    // Access acceptance: only from IDLE or OPEN, and refresh takes precedence
    always_comb begin
        take_o = 1'b0;
        if (req_valid_i && !rfsh_req_i && dram_en_i) begin
            if (st_q == ST_IDLE)                       take_o = 1'b1;
            else if (st_q == ST_OPEN && cfg_ras_down_i) take_o = 1'b1;
        end
    end

    // Next-state decode
    always_comb begin
        st_d     = st_q;
        pre_rf_d = pre_rf_q;
        unique case (st_q)
            ST_IDLE: begin
                if (dram_en_i && rfsh_req_i) st_d = ST_RFC;
                else if (take_o)             st_d = ST_ROW;
            end
            ST_OPEN: begin
                if (!hold_open) begin
                    st_d = ST_IDLE;
                end else if (rfsh_req_i) begin
                    st_d     = ST_PRE;
                    pre_rf_d = 1'b1;
                end else if (take_o) begin
                    if (row_hit_i) begin
                        st_d = ST_COL;
                    end else begin
                        st_d     = ST_PRE;
                        pre_rf_d = 1'b0;
                    end
                end
            end
            ST_PRE:  st_d = pre_rf_q ? ST_RFC : ST_ROW;
            ST_ROW:  st_d = ST_COL;
            ST_COL:  if (col_end) st_d = hold_open ? ST_OPEN : ST_IDLE;
            ST_RFC:  st_d = ST_RFR;
            ST_RFR:  if (rf_end) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // State, phase, counter and pitch registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            ph_q     <= 1'b0;
            long_q   <= 1'b0;
            pre_rf_q <= 1'b0;
            cnt_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            st_q     <= st_d;
            pre_rf_q <= pre_rf_d;
            done_q   <= col_end || rf_end;
            ph_q     <= (st_q == ST_COL);
            if (take_o) long_q <= req_write_i ? cfg_wr_long_i : cfg_rd_long_i;
            if (st_q == ST_RFC)
                cnt_q <= cfg_rd_long_i ? cfg_rfsh_wait_i : '0;
            else if (st_q == ST_RFR && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign state_o = st_q;
    assign done_o  = done_q;

    // R7: a short column phase occupies a single state
    p_short_col_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_COL && !long_q) |=> (st_q != ST_COL));

    // R8: precharge lasts exactly one state before a row or refresh phase
    p_pre_one_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PRE) |=> (st_q == ST_ROW || st_q == ST_RFC));

    // R1: a disabled idle controller stays idle
    p_disabled_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !dram_en_i) |=> (st_q == ST_IDLE));

    // R9: an open row closes once RAS-down mode is withdrawn
    p_open_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OPEN && !cfg_ras_down_i) |=> (st_q == ST_IDLE));

endmodule

// File: rtl/dram_addr_path.sv
// Row/column split and address multiplexer.
// Assumes: the address is captured on the cycle the sequencer takes a
// request; the last accessed row is the open one while the sequencer is in OPEN.
module dram_addr_path
    import dram_ctl_pkg::*;
#(
    parameter int ROW_W = 8,
    parameter int COL_W = 8,
    parameter int MUX_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   take_i,
    input  logic [ROW_W+COL_W:0]   req_addr_i,
    input  logic                   req_bus16_i,
    input  dstate_e                state_i,
    output logic                   row_hit_o,
    output logic [MUX_W-1:0]       mux_addr_o
);

    localparam int WA_W = ROW_W + COL_W;

    logic [WA_W-1:0]  req_wa;
    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;
    logic [ROW_W-1:0] cur_row;
    logic [COL_W-1:0] cur_col;

    // Word address: drop the byte bit on a 16-bit space
    assign req_wa  = req_bus16_i ? req_addr_i[WA_W:1] : req_addr_i[WA_W-1:0];
    assign req_row = req_wa[WA_W-1:COL_W];
    assign req_col = req_wa[COL_W-1:0];

    // Capture row and column of the accepted access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_row <= '0;
            cur_col <= '0;
        end else if (take_i) begin
            cur_row <= req_row;
            cur_col <= req_col;
        end
    end

    // Same-row detection against the row last opened
    assign row_hit_o = (req_row == cur_row);

    // Drive the row during the row state, the column otherwise
    always_comb begin
        mux_addr_o = '0;
        if (state_i == ST_ROW) mux_addr_o[ROW_W-1:0] = cur_row;
        else                   mux_addr_o[COL_W-1:0] = cur_col;
    end

    // R3: the column address does not move inside the column phase
    p_col_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_COL && $past(state_i) == ST_COL) |-> $stable(mux_addr_o));

endmodule

// File: rtl/dram_lane_dec.sv
// Byte-lane and strobe decoder.
// Assumes: transfer attributes are captured when the request is taken;
// strobes are active low and decoded from the sequencer state.
module dram_lane_dec
    import dram_ctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    take_i,
    input  logic    req_write_i,
    input  logic    req_word_i,
    input  logic    req_a0_i,
    input  logic    req_bus16_i,
    input  logic    cfg_dual_we_i,
    input  dstate_e state_i,
    output logic    ras_n_o,
    output logic    cas_hi_n_o,
    output logic    cas_lo_n_o,
    output logic    we_hi_n_o,
    output logic    we_lo_n_o
);

    xfer_t xq;
    logic  in_col;
    logic  in_rf;
    logic  hi_lane;
    logic  lo_lane;

    // Capture the transfer attributes when the request is taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xq <= '0;
        end else if (take_i) begin
            xq.write   <= req_write_i;
            xq.word    <= req_word_i;
            xq.a0      <= req_a0_i;
            xq.bus16   <= req_bus16_i;
            xq.dual_we <= cfg_dual_we_i;
        end
    end

    // Lane selection: upper byte on even address, lower on odd, both for a word
    always_comb begin
        in_col  = (state_i == ST_COL);
        in_rf   = (state_i == ST_RFC) || (state_i == ST_RFR);
        hi_lane = xq.bus16 && (xq.word || !xq.a0);
        lo_lane = !xq.bus16 || xq.word || xq.a0;
    end

    // Strobe decode per select mode
    always_comb begin
        ras_n_o    = !(state_i inside {ST_OPEN, ST_ROW, ST_COL, ST_RFR});
        cas_hi_n_o = !((in_col && xq.bus16 && !xq.dual_we && hi_lane) || in_rf);
        cas_lo_n_o = !((in_col && (!xq.bus16 || xq.dual_we || lo_lane)) || in_rf);
        we_hi_n_o  = !(in_col && xq.write && xq.bus16 && xq.dual_we && hi_lane);
        we_lo_n_o  = !(in_col && xq.write && (!xq.bus16 || !xq.dual_we || lo_lane));
    end

    // R6: a narrow space never drives the upper-lane strobes
    p_narrow_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_COL && !xq.bus16) |-> (cas_hi_n_o && we_hi_n_o));

    // R5: a read never asserts a write strobe
    p_read_no_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_COL && !xq.write) |-> (we_hi_n_o && we_lo_n_o));

endmodule

// File: rtl/dram_strobe_ctrl.sv
// Top level of the DRAM strobe and refresh controller.
// Assumes: one DRAM area; requests are single-cycle strobes issued only
// while the controller is idle or holding a row open; synchronous reset.
module dram_strobe_ctrl
    import dram_ctl_pkg::*;
#(
    parameter  int ROW_W  = 8,
    parameter  int COL_W  = 8,
    parameter  int RFW_W  = 2,
    localparam int ADDR_W = ROW_W + COL_W + 1,
    localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dram_en,
    input  logic              cfg_dual_we,
    input  logic              cfg_ras_down,
    input  logic              cfg_rd_long,
    input  logic              cfg_wr_long,
    input  logic [RFW_W-1:0]  cfg_rfsh_wait,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_word,
    input  logic              req_bus16,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              rfsh_req,
    input  logic              wait_n,
    output logic              ras_n,
    output logic              cas_hi_n,
    output logic              cas_lo_n,
    output logic              we_hi_n,
    output logic              we_lo_n,
    output logic [MUX_W-1:0]  mux_addr,
    output logic              done
);

    dstate_e state;
    logic    take;
    logic    row_hit;

    dram_seq #(.RFW_W(RFW_W)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .dram_en_i      (dram_en),
        .cfg_ras_down_i (cfg_ras_down),
        .cfg_rd_long_i  (cfg_rd_long),
        .cfg_wr_long_i  (cfg_wr_long),
        .cfg_rfsh_wait_i(cfg_rfsh_wait),
        .req_valid_i    (req_valid),
        .req_write_i    (req_write),
        .rfsh_req_i     (rfsh_req),
        .row_hit_i      (row_hit),
        .wait_n_i       (wait_n),
        .state_o        (state),
        .take_o         (take),
        .done_o         (done)
    );

    dram_addr_path #(.ROW_W(ROW_W), .COL_W(COL_W), .MUX_W(MUX_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_i     (take),
        .req_addr_i (req_addr),
        .req_bus16_i(req_bus16),
        .state_i    (state),
        .row_hit_o  (row_hit),
        .mux_addr_o (mux_addr)
    );

    dram_lane_dec u_lane (
        .clk          (clk),
        .rst_n        (rst_n),
        .take_i       (take),
        .req_write_i  (req_write),
        .req_word_i   (req_word),
        .req_a0_i     (req_addr[0]),
        .req_bus16_i  (req_bus16),
        .cfg_dual_we_i(cfg_dual_we),
        .state_i      (state),
        .ras_n_o      (ras_n),
        .cas_hi_n_o   (cas_hi_n),
        .cas_lo_n_o   (cas_lo_n),
        .we_hi_n_o    (we_hi_n),
        .we_lo_n_o    (we_lo_n)
    );

    // R10: whenever RAS falls with CAS low, CAS already fell one state earlier
    p_cbr_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !cas_lo_n) |-> $past(!cas_lo_n));

    // R2: the completion flag is a single-cycle pulse
    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/dram_strobe_ctrl_tb_top.sv
`timescale 1ns/1ps
module dram_strobe_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dram_en = 1'b1;
    logic        cfg_dual_we = 1'b0;
    logic        cfg_ras_down = 1'b0;
    logic        cfg_rd_long = 1'b0;
    logic        cfg_wr_long = 1'b0;
    logic [1:0]  cfg_rfsh_wait = 2'd0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_word = 1'b0;
    logic        req_bus16 = 1'b1;
    logic [16:0] req_addr = '0;
    logic        rfsh_req = 1'b0;
    logic        wait_n = 1'b1;
    logic        ras_n, cas_hi_n, cas_lo_n, we_hi_n, we_lo_n, done;
    logic [7:0]  mux_addr;

    dram_strobe_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .dram_en(dram_en), .cfg_dual_we(cfg_dual_we),
        .cfg_ras_down(cfg_ras_down), .cfg_rd_long(cfg_rd_long),
        .cfg_wr_long(cfg_wr_long), .cfg_rfsh_wait(cfg_rfsh_wait),
        .req_valid(req_valid), .req_write(req_write), .req_word(req_word),
        .req_bus16(req_bus16), .req_addr(req_addr), .rfsh_req(rfsh_req),
        .wait_n(wait_n), .ras_n(ras_n), .cas_hi_n(cas_hi_n), .cas_lo_n(cas_lo_n),
        .we_hi_n(we_hi_n), .we_lo_n(we_lo_n), .mux_addr(mux_addr), .done(done)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        bit         is_rf;
        bit         row_seen;
        logic [7:0] row;
        logic [7:0] col;
        logic [3:0] lanes;
        int         lat;
        bit         ras_after;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    int   done_cnt = 0;
    bit   finished = 0;
    bit   m_open = 0;
    logic [7:0] m_row = '0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Monitor: tracks one transfer at a time and compares against the queue head
    initial begin
        bit         active = 0;
        int         mcnt = 0;
        exp_t       cur;
        bit         cas_seen = 0;
        bit         row_got_f = 0;
        logic [7:0] row_got = '0;
        logic [7:0] col_got = '0;
        logic [3:0] lanes_got = '0;
        logic       ras_at_cas = 1'b0;
        logic       prev_ras = 1'b1;
        forever begin
            @(negedge clk);
            #1;
            if (done) done_cnt++;
            if (active) begin
                mcnt++;
                if (prev_ras && !ras_n && cas_hi_n && cas_lo_n && !row_got_f) begin
                    row_got_f = 1;
                    row_got   = mux_addr;
                end
                if (!cas_seen && (!cas_hi_n || !cas_lo_n)) begin
                    cas_seen   = 1;
                    lanes_got  = {~cas_hi_n, ~cas_lo_n, ~we_hi_n, ~we_lo_n};
                    col_got    = mux_addr;
                    ras_at_cas = ras_n;
                end
                if (done) begin
                    chk(mcnt == cur.lat, cur.tag, "latency", mcnt, cur.lat);
                    chk(ras_n == cur.ras_after, cur.tag, "ras_n after done",
                        int'(ras_n), int'(cur.ras_after));
                    chk(cas_seen && lanes_got == cur.lanes, cur.tag, "strobe lanes",
                        int'(lanes_got), int'(cur.lanes));
                    if (cur.is_rf) begin
                        chk(ras_at_cas == 1'b1, cur.tag, "ras_n when cas fell",
                            int'(ras_at_cas), 1);
                        chk(cas_hi_n && cas_lo_n, cur.tag, "cas released",
                            int'({cas_hi_n, cas_lo_n}), 3);
                    end else begin
                        chk(col_got == cur.col, cur.tag, "column address",
                            int'(col_got), int'(cur.col));
                        chk(row_got_f == cur.row_seen, cur.tag, "row phase present",
                            int'(row_got_f), int'(cur.row_seen));
                        if (cur.row_seen && row_got_f)
                            chk(row_got == cur.row, cur.tag, "row address",
                                int'(row_got), int'(cur.row));
                    end
                    void'(q.pop_front());
                    active = 0;
                end
            end
            if (!active && q.size() > 0 && (req_valid || rfsh_req)) begin
                active    = 1;
                mcnt      = 0;
                cur       = q[0];
                cas_seen  = 0;
                row_got_f = 0;
            end
            prev_ras = ras_n;
        end
    end

    task automatic wait_for_done(input int d0, input string tag);
        int guard = 0;
        while (done_cnt <= d0 && guard < 80) begin
            @(negedge clk);
            #2;
            guard++;
        end
        if (done_cnt <= d0) chk(0, tag, "done timeout", 0, 1);
        @(negedge clk);
    endtask

    // Driver: computes the expected item, queues it, then drives the request
    task automatic do_acc(input logic [16:0] addr, input bit wr, input bit word,
                          input bit b16, input int w, input string tag);
        exp_t e;
        logic [15:0] wa;
        bit hi_l, lo_l, longp, hit;
        int colc, col1;
        int d0;
        wa    = b16 ? addr[16:1] : addr[15:0];
        hi_l  = b16 && (word || !addr[0]);
        lo_l  = !b16 || word || addr[0];
        e.is_rf = 0;
        e.row   = wa[15:8];
        e.col   = wa[7:0];
        e.lanes = {b16 && !cfg_dual_we && hi_l,
                   !b16 || cfg_dual_we || lo_l,
                   wr && b16 && cfg_dual_we && hi_l,
                   wr && (!b16 || !cfg_dual_we || lo_l)};
        longp = wr ? cfg_wr_long : cfg_rd_long;
        colc  = longp ? 2 + w : 1;
        if (m_open && cfg_ras_down) begin
            hit        = (e.row == m_row);
            e.lat      = hit ? colc + 1 : colc + 3;
            e.row_seen = !hit;
        end else begin
            e.lat      = colc + 2;
            e.row_seen = 1;
        end
        e.ras_after = !cfg_ras_down;
        e.tag       = tag;
        col1        = e.lat - colc;
        q.push_back(e);
        d0 = done_cnt;
        req_addr  = addr;
        req_write = wr;
        req_word  = word;
        req_bus16 = b16;
        req_valid = 1'b1;
        if (w > 0) wait_n = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        if (w > 0) begin
            repeat (col1 + w) @(negedge clk);
            wait_n = 1'b1;
        end
        wait_for_done(d0, tag);
        m_open = cfg_ras_down;
        m_row  = e.row;
    endtask

    task automatic do_rf(input bit with_req, input string tag);
        exp_t e;
        int d0;
        e.is_rf     = 1;
        e.row_seen  = 0;
        e.row       = '0;
        e.col       = '0;
        e.lanes     = 4'b1100;
        e.lat       = 3 + (cfg_rd_long ? int'(cfg_rfsh_wait) : 0)
                        + ((m_open && cfg_ras_down) ? 1 : 0);
        e.ras_after = 1;
        e.tag       = tag;
        q.push_back(e);
        d0 = done_cnt;
        rfsh_req  = 1'b1;
        req_valid = with_req;
        wait_n    = 1'b0;
        @(negedge clk);
        rfsh_req  = 1'b0;
        req_valid = 1'b0;
        wait_for_done(d0, tag);
        wait_n = 1'b1;
        m_open = 0;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            chk(0, "watchdog", "run did not finish", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int d0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ras_n && cas_hi_n && cas_lo_n, "R1", "strobes after reset",
            int'({ras_n, cas_hi_n, cas_lo_n}), 7);
        chk(we_hi_n && we_lo_n && !done, "R1", "write strobes/done after reset",
            int'({we_hi_n, we_lo_n, done}), 6);

        // Dual-CAS lanes (R4), address split (R3), basic sequence (R2)
        do_acc(17'h1_2345, 0, 1, 1, 0, "R2/R3/R4 word read");
        do_acc(17'h0_4A10, 1, 0, 1, 0, "R4 upper write");
        do_acc(17'h0_4A11, 1, 0, 1, 0, "R4 lower write");

        // Dual-WE lanes (R5)
        cfg_dual_we = 1'b1;
        do_acc(17'h1_0F02, 1, 0, 1, 0, "R5 upper write");
        do_acc(17'h0_8888, 0, 1, 1, 0, "R5 word read");
        do_acc(17'h0_8889, 1, 0, 1, 0, "R5 lower write");

        // 8-bit space (R6)
        do_acc(17'h0_ABCD, 1, 0, 0, 0, "R3/R6 narrow write");
        do_acc(17'h0_1234, 0, 1, 0, 0, "R6 narrow read");
        cfg_dual_we = 1'b0;

        // Pitch (R7)
        cfg_rd_long = 1'b1;
        do_acc(17'h0_2200, 0, 1, 1, 0, "R7 long read");
        do_acc(17'h0_2202, 0, 1, 1, 3, "R7 long read wait3");
        do_acc(17'h0_2204, 1, 1, 1, 2, "R7 short write ignores wait");
        cfg_wr_long = 1'b1;
        do_acc(17'h0_2206, 1, 1, 1, 1, "R7 long write wait1");
        cfg_rd_long = 1'b0;
        cfg_wr_long = 1'b0;
        do_acc(17'h0_2208, 0, 1, 1, 2, "R7 short read ignores wait");

        // RAS-down mode (R8)
        cfg_ras_down = 1'b1;
        do_acc(17'h0_1204, 0, 1, 1, 0, "R8 open row");
        do_acc(17'h0_1210, 0, 1, 1, 0, "R8 same row");
        do_acc(17'h1_F000, 1, 1, 1, 0, "R8 row miss");
        cfg_rd_long = 1'b1;
        do_acc(17'h1_F0AA, 0, 1, 1, 1, "R7/R8 long hit");
        cfg_rd_long = 1'b0;

        // Refresh from an open row (R10)
        cfg_rfsh_wait = 2'd2;
        do_rf(0, "R10 refresh from open row");
        do_acc(17'h0_0400, 0, 1, 1, 0, "R8 reopen after refresh");

        // Leaving RAS-down (R9)
        cfg_ras_down = 1'b0;
        @(negedge clk);
        chk(ras_n == 1'b1, "R9", "ras_n after mode off", int'(ras_n), 1);
        m_open = 0;
        cfg_ras_down = 1'b1;
        do_acc(17'h0_0600, 0, 1, 1, 0, "R8 open again");
        dram_en = 1'b0;
        @(negedge clk);
        chk(ras_n == 1'b1, "R9", "ras_n after disable", int'(ras_n), 1);
        m_open = 0;
        dram_en = 1'b1;
        cfg_ras_down = 1'b0;
        @(negedge clk);

        // Refresh from idle (R10)
        cfg_rd_long = 1'b1;
        do_rf(0, "R10 refresh long pitch wait2");
        cfg_rd_long = 1'b0;
        cfg_rfsh_wait = 2'd3;
        do_rf(0, "R10 refresh short pitch");

        // Refresh wins over an access in the same cycle (R10)
        do_rf(1, "R10 refresh priority");
        d0 = done_cnt;
        repeat (5) @(negedge clk);
        chk(done_cnt == d0, "R10", "dropped access produced done", done_cnt - d0, 0);

        // Disabled controller ignores requests (R1)
        dram_en = 1'b0;
        req_addr = 17'h0_5555;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        rfsh_req = 1'b1;
        @(negedge clk);
        rfsh_req = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(ras_n && cas_hi_n && cas_lo_n && !done, "R1", "disabled strobes",
                int'({ras_n, cas_hi_n, cas_lo_n, done}), 14);
        end
        dram_en = 1'b1;

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule